// File: doc/BRIEF.md
# Banked External Interrupt Controller

This block watches a set of external input lines, grouped in banks of 32, and turns their activity into one interrupt output per line. Each line is either a configurable line or a direct line. A configurable line is edge-latched. A rising or falling transition, each enabled by its own select bit, records a pending flag and raises the line's output for one clock. A direct line has no pending flag, and its output copies the input level while the line is unmasked. Software can also pend configurable lines by setting bits in a software trigger register. It acknowledges them by writing ones to the pending register.

Every bank has its own set of six 32-bit registers on a simple synchronous bus. A bank's interrupt mask decides which of its lines may act at all. Module parameters fix three things per bank: which lines exist, which of them are configurable, and the reset value of the mask. Register writes are trimmed to those lines. Output `irq_o[i + 32*b]` belongs to line i of bank b. The inputs must already be synchronous to `clk`.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, each bank's interrupt mask reads its parameter value (bank 0: 0xFFFF0000, bank 1: 0x000000F0 by default). The event mask, rising select, falling select, software trigger and pending registers all read 0. All outputs are 0, and the recorded input levels are 0.
- R2: The byte offsets within a bank are: interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. Bank b starts at 0x20*b, so `bus_addr[5]` selects the bank by default. An aligned read of 0x18 or 0x1C in any bank returns 0.
- R3: Writes to the interrupt and event masks are ANDed with the bank's valid-line mask. Writes to the rising select, falling select and software trigger registers are ANDed with the bank's configurable-line mask.
- R4: For an unmasked direct line (valid and not configurable), a change of the input at a clock edge changes the output to the new level at that same edge. The output then holds that level.
- R5: For an unmasked configurable line, a 0-to-1 change with the rising select bit set, or a 1-to-0 change with the falling select bit set, sets the pending bit at that edge. It also drives the output high for exactly one cycle. A transition whose select bit is clear does neither.
- R6: While a line's interrupt mask bit is 0, its transitions set no pending bit and change no output. The level is still recorded, so unmasking the line later does not act on a transition that happened while it was masked.
- R7: A software trigger write pends and pulses (for one cycle) only those bits that go from 0 to 1, belong to unmasked lines and are not already pending. The register then reads back the trimmed written value. Rewriting a bit that is already 1 has no effect.
- R8: Writing the pending register clears each pending configurable bit written as 1, together with the matching software trigger bit. Bits written as 0 are unchanged.
- R9: An access with `bus_addr[1:0]` not equal to 0 is ignored: a write changes nothing and a read returns 0.
- R10: If a configurable line's edge event and a write-1-to-clear of the same pending bit happen in the same cycle, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NBANK*32 | External lines, already synchronous to clk |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (bank select above bit 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected or misaligned |
| irq_o | output | NBANK*32 | Per-line interrupt outputs |

## Verification
The directed part drives one-bit patterns so that each outcome can be told apart from the others: a single rising edge, and a single falling edge, on lines with only one select bit set. It also toggles a line while it is masked and then unmasks it, which separates level recording from edge latching. A software trigger is written twice with the same value to separate new bits from bits that were already set. An edge is placed in the same cycle as a clear of the same pending bit. After that, sparse random toggles on all lines are mixed with random register writes and reads. These are compared every cycle against a bench model of the registers. This exposes interactions between masking, select bits and software triggering that the directed cases do not combine.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned BANK_W = 32;

  typedef enum logic [2:0] {
    RG_IMASK = 3'd0,
    RG_EMASK = 3'd1,
    RG_RSEL  = 3'd2,
    RG_FSEL  = 3'd3,
    RG_SWTRG = 3'd4,
    RG_PEND  = 3'd5
  } reg_idx_e;

  function automatic logic [BANK_W-1:0] edge_hits(
      input logic [BANK_W-1:0] lvl_new,
      input logic [BANK_W-1:0] active,
      input logic [BANK_W-1:0] rsel,
      input logic [BANK_W-1:0] fsel);
    return active & ((lvl_new & rsel) | (~lvl_new & fsel));
  endfunction

  function automatic logic [BANK_W-1:0] sw_fresh(
      input logic [BANK_W-1:0] wr_val,
      input logic [BANK_W-1:0] old_sw,
      input logic [BANK_W-1:0] imask,
      input logic [BANK_W-1:0] pend);
    return wr_val & ~old_sw & imask & ~pend;
  endfunction
endpackage

// File: rtl/xirq_level_track.sv
module xirq_level_track #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= line_i;
  end

  assign lvl_o = lvl_q;
  assign chg_o = line_i ^ lvl_q;
endmodule

// File: rtl/xirq_bank.sv
module xirq_bank
  import xirq_pkg::*;
#(
  parameter logic [31:0] VALID  = 32'hFFFF_FFFF,
  parameter logic [31:0] CFG    = 32'h0000_FFFF,
  parameter logic [31:0] IMR_RV = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] line_i,
  input  logic        wr_en,
  input  logic [2:0]  reg_idx,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] irq_o
);
  localparam logic [31:0] DIR = VALID & ~CFG;
  localparam logic [31:0] CFGV = VALID & CFG;

  logic [31:0] imr_q, emr_q, rs_q, fs_q, sw_q, pr_q, irq_q;
  logic [31:0] lvl_prev, chg;
  logic [31:0] ev_en, hw_set, sw_set, clr;
  logic        sw_wr, pr_wr;

  xirq_level_track #(.W(32)) u_track (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .lvl_o(lvl_prev), .chg_o(chg)
  );

  always_comb begin
    ev_en  = chg & imr_q;
    hw_set = edge_hits(line_i, ev_en & CFGV, rs_q, fs_q);
    sw_wr  = wr_en && (reg_idx == RG_SWTRG);
    pr_wr  = wr_en && (reg_idx == RG_PEND);
    sw_set = sw_wr ? sw_fresh(wdata & CFGV, sw_q, imr_q, pr_q) : '0;
    clr    = pr_wr ? (pr_q & wdata & CFGV) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q <= IMR_RV & VALID;
      emr_q <= '0;
      rs_q  <= '0;
      fs_q  <= '0;
      sw_q  <= '0;
      pr_q  <= '0;
      irq_q <= '0;
    end else begin
      if (wr_en && reg_idx == RG_IMASK) imr_q <= wdata & VALID;
      if (wr_en && reg_idx == RG_EMASK) emr_q <= wdata & VALID;
      if (wr_en && reg_idx == RG_RSEL)  rs_q  <= wdata & CFGV;
      if (wr_en && reg_idx == RG_FSEL)  fs_q  <= wdata & CFGV;
      if (sw_wr)      sw_q <= wdata & CFGV;
      else if (pr_wr) sw_q <= sw_q & ~clr;
      pr_q  <= (pr_q & ~clr) | hw_set | sw_set;
      irq_q <= (irq_q & DIR & ~ev_en) | (line_i & DIR & ev_en) | hw_set | sw_set;
    end
  end

  always_comb begin
    case (reg_idx)
      RG_IMASK: rdata = imr_q;
      RG_EMASK: rdata = emr_q;
      RG_RSEL:  rdata = rs_q;
      RG_FSEL:  rdata = fs_q;
      RG_SWTRG: rdata = sw_q;
      RG_PEND:  rdata = pr_q;
      default:  rdata = '0;
    endcase
  end

  assign irq_o = irq_q;

  assert_fields_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((imr_q | emr_q) & ~VALID) == 0 && ((rs_q | fs_q | sw_q) & ~CFGV) == 0);

  assert_direct_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((irq_q ^ $past(line_i)) & DIR & $past(ev_en)) == 0));

  assert_edge_pends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(hw_set) & ~pr_q) == 0));

  assert_pulse_has_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q & CFGV & ~pr_q) == 0);

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((($past(pr_q) ^ pr_q) & ~$past(clr) & ~$past(imr_q)) == 0));

  assert_sw_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(sw_set) & ~pr_q) == 0));

  assert_clear_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(clr) & sw_q) == 0));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(clr) & ~$past(hw_set) & pr_q) == 0));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int unsigned NBANK = 2,
  parameter logic [NBANK*32-1:0] VALID_MASK = {32'h0000_00FF, 32'hFFFF_FFFF},
  parameter logic [NBANK*32-1:0] CFG_MASK   = {32'h0000_000F, 32'h0000_FFFF},
  parameter logic [NBANK*32-1:0] IMR_RESET  = {32'h0000_00F0, 32'hFFFF_0000},
  localparam int unsigned BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int unsigned ADDR_W = BSEL_W + 5,
  localparam int unsigned NLINE  = NBANK * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINE-1:0]  line_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NLINE-1:0]  irq_o
);
  logic              aligned;
  logic [BSEL_W-1:0] bank_sel;
  logic [2:0]        reg_idx;
  logic [31:0]       rd_bank [NBANK];

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign bank_sel = bus_addr[ADDR_W-1:5];
  assign reg_idx  = bus_addr[4:2];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic wr_b;
    assign wr_b = bus_sel && bus_we && aligned && (bank_sel == BSEL_W'(b));
    xirq_bank #(
      .VALID (VALID_MASK[b*32 +: 32]),
      .CFG   (CFG_MASK[b*32 +: 32]),
      .IMR_RV(IMR_RESET[b*32 +: 32])
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .line_i(line_i[b*32 +: 32]),
      .wr_en(wr_b), .reg_idx(reg_idx), .wdata(bus_wdata),
      .rdata(rd_bank[b]), .irq_o(irq_o[b*32 +: 32])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && aligned) begin
      for (int b = 0; b < NBANK; b++) begin
        if (bank_sel == BSEL_W'(b)) bus_rdata = rd_bank[b];
      end
    end
  end

  assert_misaligned_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !aligned) |-> (bus_rdata == 0));
endmodule

// File: tb/xirq_ctrl_tb_top.sv
module xirq_ctrl_tb_top;
  localparam logic [31:0] VAL [2] = '{32'hFFFF_FFFF, 32'h0000_00FF};
  localparam logic [31:0] CFG [2] = '{32'h0000_FFFF, 32'h0000_000F};
  localparam logic [31:0] IRV [2] = '{32'hFFFF_0000, 32'h0000_00F0};

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] line = '0;
  logic        sel = 0, we = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_imr[2], m_emr[2], m_rs[2], m_fs[2], m_sw[2], m_pr[2], m_lvl[2], m_out[2];

  always #10 clk = ~clk;

  xirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] mread(input logic [5:0] a);
    int b = a[5];
    if (a[1:0] != 0) return '0;
    case (a[4:2])
      3'd0: return m_imr[b];
      3'd1: return m_emr[b];
      3'd2: return m_rs[b];
      3'd3: return m_fs[b];
      3'd4: return m_sw[b];
      3'd5: return m_pr[b];
      default: return '0;
    endcase
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 2; b++) begin
      m_imr[b] = IRV[b] & VAL[b];
      m_emr[b] = 0; m_rs[b] = 0; m_fs[b] = 0; m_sw[b] = 0;
      m_pr[b] = 0; m_lvl[b] = 0; m_out[b] = 0;
    end
  endtask

  task automatic model_step();
    for (int b = 0; b < 2; b++) begin
      logic [31:0] lv, en, hw, sw, clr, dir, cv;
      logic wr;
      logic [2:0] idx;
      cv  = VAL[b] & CFG[b];
      dir = VAL[b] & ~CFG[b];
      lv  = line[b*32 +: 32];
      en  = (lv ^ m_lvl[b]) & m_imr[b];
      hw  = en & cv & ((lv & m_rs[b]) | (~lv & m_fs[b]));
      wr  = sel && we && (addr[1:0] == 0) && (addr[5] == b[0]);
      idx = addr[4:2];
      sw  = (wr && idx == 4) ? (wdata & cv & ~m_sw[b] & m_imr[b] & ~m_pr[b]) : '0;
      clr = (wr && idx == 5) ? (m_pr[b] & wdata & cv) : '0;
      m_out[b] = (m_out[b] & dir & ~en) | (lv & dir & en) | hw | sw;
      m_pr[b]  = (m_pr[b] & ~clr) | hw | sw;
      if (wr && idx == 4) m_sw[b] = wdata & cv;
      else if (wr && idx == 5) m_sw[b] = m_sw[b] & ~clr;
      if (wr && idx == 0) m_imr[b] = wdata & VAL[b];
      if (wr && idx == 1) m_emr[b] = wdata & VAL[b];
      if (wr && idx == 2) m_rs[b] = wdata & cv;
      if (wr && idx == 3) m_fs[b] = wdata & cv;
      m_lvl[b] = lv;
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (irq !== {m_out[1], m_out[0]}) begin
      fails++;
      $display("FAIL %s irq_o actual=%h expected=%h", tag, irq, {m_out[1], m_out[0]});
    end
  endtask

  task automatic rd_chk(input logic [5:0] a, input string tag);
    sel = 1; we = 0; addr = a;
    #1;
    checks++;
    if (rdata !== mread(a)) begin
      fails++;
      $display("FAIL %s read @%h actual=%h expected=%h", tag, a, rdata, mread(a));
    end
    tick(tag);
    sel = 0;
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d, input string tag);
    sel = 1; we = 1; addr = a; wdata = d;
    tick(tag);
    sel = 0; we = 0;
  endtask

  task automatic set_line(input int n, input logic v, input string tag);
    line[n] = v;
    tick(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (irq !== '0) begin
      fails++;
      $display("FAIL R1 irq_o in reset actual=%h expected=0", irq);
    end
    rst_n = 1;
    tick("R1");
    // R1: all registers of both banks after reset
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 6; r++) rd_chk(6'(b * 32 + r * 4), "R1");
    // R2: unmapped aligned offsets read zero
    rd_chk(6'h18, "R2"); rd_chk(6'h1C, "R2"); rd_chk(6'h38, "R2");
    // R3: write trimming
    bus_wr(6'h00, 32'hFFFF_FFFF, "R3"); rd_chk(6'h00, "R3");
    bus_wr(6'h24, 32'hFFFF_FFFF, "R3"); rd_chk(6'h24, "R3");
    bus_wr(6'h28, 32'hFFFF_FFFF, "R3"); rd_chk(6'h28, "R3");
    bus_wr(6'h28, 32'h0, "R3");
    // R5: bit0 rising select, bit1 falling select
    bus_wr(6'h08, 32'h1, "R5");
    bus_wr(6'h0C, 32'h2, "R5");
    set_line(0, 1, "R5"); tick("R5"); rd_chk(6'h14, "R5");
    set_line(1, 1, "R5"); rd_chk(6'h14, "R5");
    set_line(1, 0, "R5"); tick("R5"); rd_chk(6'h14, "R5");
    // R8: clear one bit, write zero
    bus_wr(6'h14, 32'h1, "R8"); rd_chk(6'h14, "R8");
    bus_wr(6'h14, 32'h0, "R8"); rd_chk(6'h14, "R8");
    bus_wr(6'h14, 32'h2, "R8"); rd_chk(6'h14, "R8");
    // R4: direct lines 16 and bank1 line 36
    set_line(16, 1, "R4"); tick("R4"); set_line(16, 0, "R4");
    set_line(36, 1, "R4"); set_line(36, 0, "R4");
    // R6: masked toggling then unmask
    bus_wr(6'h00, 32'hFFFF_FFFE, "R6");
    set_line(0, 0, "R6"); set_line(0, 1, "R6"); rd_chk(6'h14, "R6");
    bus_wr(6'h00, 32'hFFFF_FFFF, "R6"); tick("R6"); rd_chk(6'h14, "R6");
    bus_wr(6'h00, 32'hFFFE_FFFF, "R6"); set_line(16, 1, "R6"); tick("R6");
    bus_wr(6'h00, 32'hFFFF_FFFF, "R6"); set_line(16, 0, "R6");
    // R7: software trigger
    bus_wr(6'h10, 32'h4, "R7"); rd_chk(6'h14, "R7"); rd_chk(6'h10, "R7");
    bus_wr(6'h10, 32'h4, "R7"); rd_chk(6'h14, "R7");
    bus_wr(6'h14, 32'h4, "R8"); rd_chk(6'h10, "R8"); rd_chk(6'h14, "R8");
    bus_wr(6'h00, 32'hFFFF_FFF7, "R7");
    bus_wr(6'h10, 32'h8, "R7"); rd_chk(6'h14, "R7");
    bus_wr(6'h00, 32'hFFFF_FFFF, "R7");
    // R10: edge and clear of the same bit in one cycle
    set_line(0, 0, "R10");
    bus_wr(6'h10, 32'h1, "R10"); rd_chk(6'h14, "R10");
    line[0] = 1;
    bus_wr(6'h14, 32'h1, "R10"); rd_chk(6'h14, "R10");
    // R9: misaligned accesses
    bus_wr(6'h01, 32'h0, "R9"); rd_chk(6'h00, "R9");
    bus_wr(6'h16, 32'hFFFF_FFFF, "R9"); rd_chk(6'h14, "R9");
    rd_chk(6'h02, "R9"); rd_chk(6'h23, "R9");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      line = line ^ {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      if (($urandom % 4) == 0) begin
        logic [5:0] a;
        a = 6'($urandom);
        if (($urandom % 8) != 0) a[1:0] = 2'b00;
        bus_wr(a, $urandom, "R5");
      end else if (($urandom % 6) == 0) begin
        rd_chk(6'($urandom) & 6'h3C, "R7");
      end else begin
        tick("R4");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule